// File: doc/BRIEF.md
# Hoisted-Load Conflict Table

This block keeps track of loads that a compiler has moved above earlier stores whose addresses were still unknown at scheduling time. When such a hoisted load executes, it records its destination register tag and its memory address in a small fully associative table. Each later store compares its address against every live entry and kills the entries that overlap. When execution reaches the load's original position, a check on the register tag asks whether the early load is still good. A passing check means the loaded value can be used. A failing check means a store overlapped the load, or the entry was lost, and the load must be redone.

Addresses are compared at doubleword (8-byte) granularity. A new hoisted load to a tag that is already held reuses that entry. Otherwise it takes the lowest-numbered free entry. When no entry is free, a victim is chosen in round-robin order. The check response is registered. It appears one cycle after the request and reflects any store presented in the same cycle as the request.

Top module: `altLoadTable`

## Requirements
- R1: After reset, and after any later reset, every entry is invalid. A check on any tag then fails, and `chkRespValid` stays low while reset is held.
- R2: An insert records its tag and address. A check on that tag passes (`chkPass`=1). `chkRespValid` is high exactly in the cycle after each check request and low in every other cycle.
- R3: A passing check frees its entry, so a second check on the same tag fails.
- R4: A check on a tag that is not held in the table fails.
- R5: A store whose address bits [63:3] equal those of a live entry invalidates that entry, whatever its low three bits are. A later check on that tag fails.
- R6: A store to a different doubleword leaves every entry unchanged.
- R7: An insert to a tag that is already held overwrites that entry's address. Afterwards a store to the old address has no effect, and the tag stays held only once.
- R8: When no entry is free and the tag is not held, the insert replaces an entry chosen in round-robin order. The pointer is 0 after reset and advances by one on each such replacement. Free entries are always taken lowest index first.
- R9: An insert and a matching store in the same cycle leave the new entry valid, because the store is treated as older.
- R10: A check and a store in the same cycle see the store first. If the store overlaps the checked entry, the check fails. If it does not overlap, the result is unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| insValid | input | 1 | Hoisted-load insert strobe |
| insTag | input | 7 | Destination register tag of the hoisted load |
| insAddr | input | 64 | Address of the hoisted load |
| stValid | input | 1 | Store address strobe |
| stAddr | input | 64 | Store address |
| chkValid | input | 1 | Check request strobe |
| chkTag | input | 7 | Register tag to check |
| chkRespValid | output | 1 | Check response valid, one cycle after the request |
| chkPass | output | 1 | 1 when the hoisted load is still good |

## Verification
A store can land in the same cycle as an insert, or in the same cycle as a check. Both orderings matter. The stimulus table holds one cycle that inserts a tag while a store hits the same doubleword; a later check on that tag must pass. It also holds one cycle that pairs a store to a live entry's doubleword with a check on that entry's tag; the response must fail. A control cycle pairs a check with a store to an unrelated address, and that check must still pass.

// File: rtl/altPkg.sv
package altPkg;
  // Wide enough to index any table this block is built with.
  localparam int unsigned IDX_CARRY_W = 8;

  typedef struct packed {
    logic                   setEn;    // write an entry this cycle
    logic [IDX_CARRY_W-1:0] setIdx;   // which entry to write
    logic                   chkFree;  // free the entry matching chkTag
    logic                   stKill;   // kill entries matching stAddr
  } tblCtrlT;
endpackage

// File: rtl/altTableDp.sv
module altTableDp
  import altPkg::*;
#(
  parameter int unsigned ENTRIES = 16,
  parameter int unsigned TAG_W   = 7,
  parameter int unsigned BLK_W   = 61
) (
  input  logic               clk,
  input  logic               rstN,
  input  tblCtrlT            ctrl,
  input  logic [TAG_W-1:0]   insTag,
  input  logic [BLK_W-1:0]   insBlk,
  input  logic [BLK_W-1:0]   stBlk,
  input  logic [TAG_W-1:0]   chkTag,
  output logic [ENTRIES-1:0] validVec,
  output logic [ENTRIES-1:0] insTagHit,
  output logic [ENTRIES-1:0] chkHit,
  output logic [ENTRIES-1:0] stHit
);
  logic [TAG_W-1:0] tagMem [ENTRIES];
  logic [BLK_W-1:0] blkMem [ENTRIES];
  logic [ENTRIES-1:0] setVec;
  logic [ENTRIES-1:0] clrVec;

  for (genvar i = 0; i < ENTRIES; i++) begin : gEntry
    assign insTagHit[i] = validVec[i] && (tagMem[i] == insTag);
    assign chkHit[i]    = validVec[i] && (tagMem[i] == chkTag);
    assign stHit[i]     = validVec[i] && (blkMem[i] == stBlk);
    assign setVec[i]    = ctrl.setEn && (ctrl.setIdx == IDX_CARRY_W'(i));
    assign clrVec[i]    = (ctrl.stKill && stHit[i]) || (ctrl.chkFree && chkHit[i]);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        validVec[i] <= 1'b0;
        tagMem[i]   <= '0;
        blkMem[i]   <= '0;
      end else if (setVec[i]) begin
        // a same-cycle store is older, so the new write wins
        validVec[i] <= 1'b1;
        tagMem[i]   <= insTag;
        blkMem[i]   <= insBlk;
      end else if (clrVec[i]) begin
        validVec[i] <= 1'b0;
      end
    end
  end

  // R7: one live entry per tag
  p_tag_unique_r7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(insTagHit));

  // R9: a written entry is live in the next cycle even under a store
  p_insert_lands_r9: assert property (@(posedge clk) disable iff (!rstN)
    (|setVec) |=> ((validVec & $past(setVec)) == $past(setVec)));

  // R5: a matching store clears the entries it hits
  p_store_kills_r5: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.stKill && |(stHit & ~setVec)) |=> ((validVec & $past(stHit & ~setVec)) == '0));
endmodule

// File: rtl/altTableCtl.sv
module altTableCtl
  import altPkg::*;
#(
  parameter int unsigned ENTRIES = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               insValid,
  input  logic               stValid,
  input  logic               chkValid,
  input  logic [ENTRIES-1:0] validVec,
  input  logic [ENTRIES-1:0] insTagHit,
  input  logic [ENTRIES-1:0] chkHit,
  input  logic [ENTRIES-1:0] stHit,
  output tblCtrlT            ctrl,
  output logic               chkRespValid,
  output logic               chkPass
);
  localparam int unsigned IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [IDX_W-1:0] rrPtr;
  logic [IDX_W-1:0] hitIdx;
  logic [IDX_W-1:0] freeIdx;
  logic [IDX_W-1:0] pickIdx;
  logic             anyFree;
  logic             replace;
  logic             passNext;

  always_comb begin
    hitIdx  = '0;
    freeIdx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (insTagHit[i]) hitIdx = IDX_W'(i);
      if (!validVec[i]) freeIdx = IDX_W'(i);   // lowest index wins
    end
  end

  assign anyFree = ~&validVec;
  assign replace = insValid && !(|insTagHit) && !anyFree;
  assign pickIdx = (|insTagHit) ? hitIdx : (anyFree ? freeIdx : rrPtr);

  assign ctrl.setEn   = insValid;
  assign ctrl.setIdx  = IDX_CARRY_W'(pickIdx);
  assign ctrl.chkFree = chkValid;
  assign ctrl.stKill  = stValid;

  // the store is older than the check in the same cycle
  assign passNext = chkValid && |(chkHit & ~(stValid ? stHit : '0));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rrPtr        <= '0;
      chkRespValid <= 1'b0;
      chkPass      <= 1'b0;
    end else begin
      chkRespValid <= chkValid;
      chkPass      <= passNext;
      if (replace)
        rrPtr <= (rrPtr == IDX_W'(ENTRIES - 1)) ? '0 : rrPtr + 1'b1;
    end
  end

  // R2: response strictly one cycle after the request
  p_resp_follows_req_r2: assert property (@(posedge clk) disable iff (!rstN)
    chkValid |=> chkRespValid);
  p_no_spurious_resp_r2: assert property (@(posedge clk) disable iff (!rstN)
    !chkValid |=> !chkRespValid);

  // R4: no live entry for the tag means failure
  p_absent_fails_r4: assert property (@(posedge clk) disable iff (!rstN)
    (chkValid && !(|chkHit)) |=> !chkPass);

  // R10: a same-cycle overlapping store defeats the check
  p_store_first_r10: assert property (@(posedge clk) disable iff (!rstN)
    (chkValid && stValid && |(chkHit & stHit)) |=> !chkPass);

  // R8: each forced replacement moves the victim pointer
  p_rr_advance_r8: assert property (@(posedge clk) disable iff (!rstN)
    (replace && ENTRIES > 1) |=> (rrPtr != $past(rrPtr)));
endmodule

// File: rtl/altLoadTable.sv
module altLoadTable
  import altPkg::*;
#(
  parameter int unsigned ENTRIES   = 16,
  parameter int unsigned TAG_W     = 7,
  parameter int unsigned ADDR_W    = 64,
  parameter int unsigned GRAN_LOG2 = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              insValid,
  input  logic [TAG_W-1:0]  insTag,
  input  logic [ADDR_W-1:0] insAddr,
  input  logic              stValid,
  input  logic [ADDR_W-1:0] stAddr,
  input  logic              chkValid,
  input  logic [TAG_W-1:0]  chkTag,
  output logic              chkRespValid,
  output logic              chkPass
);
  localparam int unsigned BLK_W = ADDR_W - GRAN_LOG2;

  tblCtrlT            ctrl;
  logic [ENTRIES-1:0] validVec;
  logic [ENTRIES-1:0] insTagHit;
  logic [ENTRIES-1:0] chkHit;
  logic [ENTRIES-1:0] stHit;
  logic               unusedLowBits;

  // bytes inside one doubleword are not told apart
  assign unusedLowBits = ^{insAddr[GRAN_LOG2-1:0], stAddr[GRAN_LOG2-1:0]};

  altTableDp #(.ENTRIES(ENTRIES), .TAG_W(TAG_W), .BLK_W(BLK_W)) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .ctrl      (ctrl),
    .insTag    (insTag),
    .insBlk    (insAddr[ADDR_W-1:GRAN_LOG2]),
    .stBlk     (stAddr[ADDR_W-1:GRAN_LOG2]),
    .chkTag    (chkTag),
    .validVec  (validVec),
    .insTagHit (insTagHit),
    .chkHit    (chkHit),
    .stHit     (stHit)
  );

  altTableCtl #(.ENTRIES(ENTRIES)) uCtl (
    .clk          (clk),
    .rstN         (rstN),
    .insValid     (insValid),
    .stValid      (stValid),
    .chkValid     (chkValid),
    .validVec     (validVec),
    .insTagHit    (insTagHit),
    .chkHit       (chkHit),
    .stHit        (stHit),
    .ctrl         (ctrl),
    .chkRespValid (chkRespValid),
    .chkPass      (chkPass)
  );
endmodule

// File: tb/tb_altLoadTable.sv
`timescale 1ns/100ps
module tb_altLoadTable;
  logic        clk = 1'b0;
  logic        rstN;
  logic        insValid;
  logic [6:0]  insTag;
  logic [63:0] insAddr;
  logic        stValid;
  logic [63:0] stAddr;
  logic        chkValid;
  logic [6:0]  chkTag;
  logic        chkRespValid;
  logic        chkPass;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  altLoadTable dut (
    .clk(clk), .rstN(rstN),
    .insValid(insValid), .insTag(insTag), .insAddr(insAddr),
    .stValid(stValid), .stAddr(stAddr),
    .chkValid(chkValid), .chkTag(chkTag),
    .chkRespValid(chkRespValid), .chkPass(chkPass)
  );

  typedef struct packed {
    logic [3:0]  req;
    logic        insV;
    logic [6:0]  insT;
    logic [15:0] insA;
    logic        stV;
    logic [15:0] stA;
    logic        chkV;
    logic [6:0]  chkT;
    logic        expPass;
  } vecT;

  localparam int NV = 21;
  localparam vecT VECS [NV] = '{
    '{4'd1,  1'b0, 7'd0,  16'h0000, 1'b0, 16'h0000, 1'b1, 7'd5,  1'b0}, // R1 empty
    '{4'd2,  1'b1, 7'd5,  16'h1000, 1'b0, 16'h0000, 1'b0, 7'd0,  1'b0}, // R2 insert
    '{4'd2,  1'b0, 7'd0,  16'h0000, 1'b0, 16'h0000, 1'b1, 7'd5,  1'b1}, // R2 pass
    '{4'd3,  1'b0, 7'd0,  16'h0000, 1'b0, 16'h0000, 1'b1, 7'd5,  1'b0}, // R3 freed
    '{4'd6,  1'b1, 7'd7,  16'h2000, 1'b0, 16'h0000, 1'b0, 7'd0,  1'b0}, // R6
    '{4'd6,  1'b0, 7'd0,  16'h0000, 1'b1, 16'h2008, 1'b0, 7'd0,  1'b0}, // R6 next dword
    '{4'd6,  1'b0, 7'd0,  16'h0000, 1'b0, 16'h0000, 1'b1, 7'd7,  1'b1}, // R6 survives
    '{4'd5,  1'b1, 7'd9,  16'h3000, 1'b0, 16'h0000, 1'b0, 7'd0,  1'b0}, // R5
    '{4'd5,  1'b0, 7'd0,  16'h0000, 1'b1, 16'h3005, 1'b0, 7'd0,  1'b0}, // R5 byte 5
    '{4'd5,  1'b0, 7'd0,  16'h0000, 1'b0, 16'h0000, 1'b1, 7'd9,  1'b0}, // R5 killed
    '{4'd4,  1'b0, 7'd0,  16'h0000, 1'b0, 16'h0000, 1'b1, 7'd42, 1'b0}, // R4 absent
    '{4'd7,  1'b1, 7'd11, 16'h4000, 1'b0, 16'h0000, 1'b0, 7'd0,  1'b0}, // R7
    '{4'd7,  1'b1, 7'd11, 16'h5000, 1'b0, 16'h0000, 1'b0, 7'd0,  1'b0}, // R7 overwrite
    '{4'd7,  1'b0, 7'd0,  16'h0000, 1'b1, 16'h4000, 1'b0, 7'd0,  1'b0}, // R7 old addr
    '{4'd7,  1'b0, 7'd0,  16'h0000, 1'b0, 16'h0000, 1'b1, 7'd11, 1'b1}, // R7 still live
    '{4'd9,  1'b1, 7'd12, 16'h6000, 1'b1, 16'h6000, 1'b0, 7'd0,  1'b0}, // R9 same cycle
    '{4'd9,  1'b0, 7'd0,  16'h0000, 1'b0, 16'h0000, 1'b1, 7'd12, 1'b1}, // R9 kept
    '{4'd10, 1'b1, 7'd13, 16'h7000, 1'b0, 16'h0000, 1'b0, 7'd0,  1'b0}, // R10
    '{4'd10, 1'b0, 7'd0,  16'h0000, 1'b1, 16'h7004, 1'b1, 7'd13, 1'b0}, // R10 store first
    '{4'd10, 1'b1, 7'd14, 16'h8000, 1'b0, 16'h0000, 1'b0, 7'd0,  1'b0}, // R10
    '{4'd10, 1'b0, 7'd0,  16'h0000, 1'b1, 16'h9000, 1'b1, 7'd14, 1'b1}  // R10 unrelated
  };

  task automatic expect1(string what, logic act, logic exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: got %0b expected %0b", what, act, exp);
    end
  endtask

  task automatic step(logic iv, logic [6:0] it, logic [63:0] ia,
                      logic sv, logic [63:0] sa, logic cv, logic [6:0] ct);
    @(negedge clk);
    insValid = iv; insTag = it; insAddr = ia;
    stValid = sv;  stAddr = sa;
    chkValid = cv; chkTag = ct;
    @(posedge clk);
    #1;
    insValid = 1'b0; stValid = 1'b0; chkValid = 1'b0;
  endtask

  task automatic doCheck(string what, logic [6:0] t, logic exp);
    step(1'b0, 7'd0, 64'd0, 1'b0, 64'd0, 1'b1, t);
    expect1({what, " resp"}, chkRespValid, 1'b1);
    expect1({what, " pass"}, chkPass, exp);
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    expect1("R1 no response in reset", chkRespValid, 1'b0);
    @(negedge clk);
    rstN = 1'b1;
  endtask

  initial begin
    rstN = 1'b0;
    insValid = 1'b0; insTag = '0; insAddr = '0;
    stValid = 1'b0; stAddr = '0; chkValid = 1'b1; chkTag = 7'd5;
    doReset();
    chkValid = 1'b0;

    for (int i = 0; i < NV; i++) begin
      step(VECS[i].insV, VECS[i].insT, {48'd0, VECS[i].insA},
           VECS[i].stV, {48'd0, VECS[i].stA}, VECS[i].chkV, VECS[i].chkT);
      expect1($sformatf("R%0d vec %0d resp", VECS[i].req, i),
              chkRespValid, VECS[i].chkV);
      if (VECS[i].chkV)
        expect1($sformatf("R%0d vec %0d pass", VECS[i].req, i),
                chkPass, VECS[i].expPass);
    end

    // R8: table is empty here, so tags 20..35 fill entries 0..15
    for (int k = 0; k < 16; k++)
      step(1'b1, 7'(20 + k), 64'(32'h10000 + 8 * k), 1'b0, 64'd0, 1'b0, 7'd0);
    step(1'b1, 7'd100, 64'h20000, 1'b0, 64'd0, 1'b0, 7'd0); // evicts entry 0
    step(1'b1, 7'd101, 64'h20100, 1'b0, 64'd0, 1'b0, 7'd0); // evicts entry 1
    doCheck("R8 first victim", 7'd20, 1'b0);
    doCheck("R8 second victim", 7'd21, 1'b0);
    doCheck("R8 survivor", 7'd22, 1'b1);
    doCheck("R8 new tag 100", 7'd100, 1'b1);
    doCheck("R8 new tag 101", 7'd101, 1'b1);

    // R1: a later reset drops live entries
    doReset();
    doCheck("R1 after second reset", 7'd23, 1'b0);

    finished = 1;
    $display("  %0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  %0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end
endmodule